// File: doc/BRIEF.md
# Serial Converter Read Sequencer

This block is the host-side master for a successive-approximation converter that has a single convert-start strobe, a busy flag and a two-wire serial read port. On a sample request it drives convert-start low for a fixed number of system clocks. It then waits until busy drops and generates exactly sixteen serial clock pulses. The clock rests low before and after the read. On every falling serial clock edge the returned bit is captured.

Of the sixteen bits, the first four must be zero; the last twelve are the conversion result, most significant bit first. The result is presented with a one-cycle valid strobe, together with a flag that reports a nonzero leading bit. A quiet interval is counted from the final serial clock edge. The next convert-start edge is withheld until that interval has passed, so a request that arrives too early is remembered and serviced late rather than dropped. The pulse width, the serial clock half period and the quiet interval are parameters counted in system clocks.

Top module: `conv_read_ctrl`

## Requirements
- R1: While reset is held and on release, convStartN is 1, sclk is 0, resultValid is 0, result is 0 and leadErr is 0.
- R2: A start request sampled at a clock edge, with no read and no quiet interval pending, drives convStartN low at that edge. It stays low for exactly CONV_LOW_CYC clocks (default 4) and then returns high.
- R3: sclk never rises while busy is high; the read starts only after busy is seen low following the convert-start pulse.
- R4: Each read is exactly 16 sclk pulses. Each pulse is high for SCLK_HALF clocks and low for SCLK_HALF clocks between pulses (default 5). sclk is held low outside a read.
- R5: The bit on sdata is captured at the clock edge where sclk falls. Received bits 15..12 (the first four) are leading bits and bits 11..0 are the result, first received bit most significant. result is the 12 result bits, and resultValid is high for exactly one clock per read.
- R6: leadErr, updated together with resultValid, is 1 when any of the four leading bits of that read was 1, and 0 otherwise.
- R7: convStartN never falls sooner than GUARD_CYC clocks (default 40) after the last sclk fall of the previous read.
- R8: A start request that arrives while a conversion, a read or the quiet interval is in progress is held. It is serviced exactly once, as soon as the interval ends (GUARD_CYC+1 clocks after the last sclk fall). Several requests arriving during one conversion produce only one extra conversion.
- R9: result and leadErr keep their values in every cycle in which resultValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request one sample (single-cycle pulse or level) |
| busy | input | 1 | Converter busy flag, high during conversion |
| sdata | input | 1 | Serial data from the converter |
| convStartN | output | 1 | Convert-start, active-low pulse |
| sclk | output | 1 | Serial read clock, parked low |
| result | output | 12 | Last conversion result |
| resultValid | output | 1 | One-cycle strobe marking a new result |
| leadErr | output | 1 | Leading bits of the last read were not all zero |

## Verification
The assertions assume that busy and sdata are synchronous to clk. They also assume that busy rises no later than the clock after convStartN falls and stays high until the conversion is done, and that sdata holds each bit until the edge at which sclk falls. The bench converter model meets these conditions. It raises busy directly on the falling convert-start edge and lowers it just after a clock edge. It advances its bit index only on a falling sclk, so the bit being captured is still on the line at the capture edge. Requests are driven between edges, including bursts during a conversion, so that the hold-off path is exercised as well as the direct path.

// File: rtl/conv_read_pkg.sv
package conv_read_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_SHIFT,
    ST_DONE
  } ctlState_t;

  typedef struct packed {
    logic clearShift;
    logic captureBit;
    logic publish;
  } dpCtl_t;

endpackage

// File: rtl/conv_read_ctl.sv
module conv_read_ctl
  import conv_read_pkg::*;
#(
  parameter int CONV_LOW_CYC = 4,
  parameter int SCLK_HALF    = 5,
  parameter int GUARD_CYC    = 40,
  parameter int WORD_BITS    = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   busy,
  output logic   convStartN,
  output logic   sclk,
  output dpCtl_t dpCtl
);

  localparam int CONV_W  = $clog2(CONV_LOW_CYC + 1);
  localparam int HALF_W  = $clog2(SCLK_HALF + 1);
  localparam int GUARD_W = $clog2(GUARD_CYC + 1);
  localparam int BIT_W   = $clog2(WORD_BITS);
  localparam logic [BIT_W-1:0]   LAST_BIT  = BIT_W'(WORD_BITS - 1);
  localparam logic [CONV_W-1:0]  CONV_LOAD = CONV_W'(CONV_LOW_CYC - 1);
  localparam logic [HALF_W-1:0]  HALF_LOAD = HALF_W'(SCLK_HALF - 1);
  localparam logic [GUARD_W-1:0] GUARD_LOAD = GUARD_W'(GUARD_CYC);

  ctlState_t          state;
  logic [CONV_W-1:0]  convCnt;
  logic [HALF_W-1:0]  phaseCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic [GUARD_W-1:0] guardCnt;
  logic               pend;
  logic               launch;
  logic               edgeFall;
  logic               lastFall;

  assign launch   = (state == ST_IDLE) && (guardCnt == '0) && (startReq || pend);
  assign edgeFall = (state == ST_SHIFT) && (phaseCnt == '0) && sclk;
  assign lastFall = edgeFall && (bitCnt == LAST_BIT);

  always_comb begin
    dpCtl.clearShift = launch;
    dpCtl.captureBit = edgeFall;
    dpCtl.publish    = (state == ST_DONE);
  end

  // request hold-off and quiet interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= 1'b0;
      guardCnt <= '0;
    end else begin
      if (launch)        pend <= 1'b0;
      else if (startReq) pend <= 1'b1;
      if (lastFall)              guardCnt <= GUARD_LOAD;
      else if (guardCnt != '0)   guardCnt <= guardCnt - 1'b1;
    end
  end

  // main sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      convStartN <= 1'b1;
      sclk       <= 1'b0;
      convCnt    <= '0;
      phaseCnt   <= '0;
      bitCnt     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            convStartN <= 1'b0;
            convCnt    <= CONV_LOAD;
            state      <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (convCnt == '0) begin
            convStartN <= 1'b1;
            state      <= ST_WAIT;
          end else begin
            convCnt <= convCnt - 1'b1;
          end
        end
        ST_WAIT: begin
          if (!busy) begin
            sclk     <= 1'b1;
            phaseCnt <= HALF_LOAD;
            bitCnt   <= '0;
            state    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (phaseCnt != '0) begin
            phaseCnt <= phaseCnt - 1'b1;
          end else begin
            phaseCnt <= HALF_LOAD;
            if (sclk) begin
              sclk <= 1'b0;
              if (bitCnt == LAST_BIT) state <= ST_DONE;
              else                    bitCnt <= bitCnt + 1'b1;
            end else begin
              sclk <= 1'b1;
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- observation counters for the properties ----------------
  logic        sclkQ;
  logic [15:0] lowRun;
  logic [31:0] sinceFall;
  logic [7:0]  risesInRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ       <= 1'b0;
      lowRun      <= '0;
      sinceFall   <= '1;
      risesInRead <= '0;
    end else begin
      sclkQ  <= sclk;
      lowRun <= convStartN ? 16'd0 : lowRun + 16'd1;
      if (sclkQ && !sclk)        sinceFall <= 32'd1;
      else if (sinceFall != '1)  sinceFall <= sinceFall + 32'd1;
      if (!convStartN)           risesInRead <= '0;
      else if (!sclkQ && sclk)   risesInRead <= risesInRead + 8'd1;
    end
  end

  // R2
  conv_pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convStartN) |-> (lowRun == 16'(CONV_LOW_CYC)));

  // R3
  no_clock_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !sclk) |=> !sclk);

  // R4
  sixteen_pulses_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |-> (risesInRead == 8'(WORD_BITS)));

  // R4
  clock_parked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !convStartN |-> !sclk);

  // R7
  guard_interval_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convStartN) |-> (sinceFall >= 32'(GUARD_CYC)));

endmodule

// File: rtl/conv_read_dp.sv
module conv_read_dp
  import conv_read_pkg::*;
#(
  parameter int LEAD_BITS = 4,
  parameter int DATA_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               dpCtl,
  input  logic                 sdata,
  output logic [DATA_BITS-1:0] result,
  output logic                 resultValid,
  output logic                 leadErr
);

  localparam int WORD_BITS = LEAD_BITS + DATA_BITS;

  logic [WORD_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (dpCtl.clearShift) begin
      shiftReg <= '0;
    end else if (dpCtl.captureBit) begin
      shiftReg <= {shiftReg[WORD_BITS-2:0], sdata};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result      <= '0;
      leadErr     <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= dpCtl.publish;
      if (dpCtl.publish) begin
        result  <= shiftReg[DATA_BITS-1:0];
        leadErr <= |shiftReg[WORD_BITS-1:DATA_BITS];
      end
    end
  end

  // R5
  valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> ($stable(result) && $stable(leadErr)));

endmodule

// File: rtl/conv_read_ctrl.sv
module conv_read_ctrl
  import conv_read_pkg::*;
#(
  parameter int CONV_LOW_CYC = 4,
  parameter int SCLK_HALF    = 5,
  parameter int GUARD_CYC    = 40,
  parameter int LEAD_BITS    = 4,
  parameter int DATA_BITS    = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic                 busy,
  input  logic                 sdata,
  output logic                 convStartN,
  output logic                 sclk,
  output logic [DATA_BITS-1:0] result,
  output logic                 resultValid,
  output logic                 leadErr
);

  localparam int WORD_BITS = LEAD_BITS + DATA_BITS;

  dpCtl_t dpCtl;

  conv_read_ctl #(
    .CONV_LOW_CYC(CONV_LOW_CYC),
    .SCLK_HALF   (SCLK_HALF),
    .GUARD_CYC   (GUARD_CYC),
    .WORD_BITS   (WORD_BITS)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .busy      (busy),
    .convStartN(convStartN),
    .sclk      (sclk),
    .dpCtl     (dpCtl)
  );

  conv_read_dp #(
    .LEAD_BITS(LEAD_BITS),
    .DATA_BITS(DATA_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtl      (dpCtl),
    .sdata      (sdata),
    .result     (result),
    .resultValid(resultValid),
    .leadErr    (leadErr)
  );

endmodule

// File: tb/conv_read_ctrl_tb.sv
module conv_read_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CONV_LOW   = 4;
  localparam int HALF       = 5;
  localparam int GUARD      = 40;
  localparam int BUSY_CYC   = 20;
  localparam int NVEC       = 6;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0ABC, 16'h0FFF, 16'h0000, 16'h0801, 16'h8123, 16'h1555
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic busy = 1'b0;
  logic sdata;
  logic convStartN, sclk, resultValid, leadErr;
  logic [11:0] result;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_read_ctrl #(
    .CONV_LOW_CYC(CONV_LOW), .SCLK_HALF(HALF), .GUARD_CYC(GUARD),
    .LEAD_BITS(4), .DATA_BITS(12)
  ) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .busy(busy), .sdata(sdata),
    .convStartN(convStartN), .sclk(sclk), .result(result),
    .resultValid(resultValid), .leadErr(leadErr)
  );

  // ---------------- converter model ----------------
  logic [15:0] nextWord = 16'h0000;
  logic [15:0] curWord  = 16'h0000;
  int fallTotal = 0;
  int fallBase  = 0;
  int riseTotal = 0;
  int convFalls = 0;
  int busyViol  = 0;
  int widthBad  = 0;
  longint tSclkRise = 0;
  longint tSclkFall = -1;
  longint tConvFall = 0;
  int lastLowWidth = 0;
  int lastGap = 0;
  int idx;

  assign idx   = fallTotal - fallBase;
  assign sdata = (idx < 16) ? curWord[15 - idx] : 1'b0;

  always @(negedge convStartN) begin
    curWord   = nextWord;
    fallBase  = fallTotal;
    convFalls = convFalls + 1;
    tConvFall = $time;
    lastGap   = (tSclkFall < 0) ? 1000000 : int'(($time - tSclkFall) / CLK_PERIOD);
    busy = 1'b1;
    repeat (BUSY_CYC) @(posedge clk);
    #1 busy = 1'b0;
  end

  always @(posedge convStartN)
    if (rstN) lastLowWidth = int'(($time - tConvFall) / CLK_PERIOD);

  always @(posedge sclk) begin
    riseTotal = riseTotal + 1;
    if (busy) busyViol = busyViol + 1;
    if (idx > 0 && idx < 16 && int'(($time - tSclkFall) / CLK_PERIOD) != HALF)
      widthBad = widthBad + 1;
    tSclkRise = $time;
  end

  always @(negedge sclk) begin
    if (int'(($time - tSclkRise) / CLK_PERIOD) != HALF) widthBad = widthBad + 1;
    fallTotal = fallTotal + 1;
    tSclkFall = $time;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseReq();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  task automatic waitValid(output bit seen);
    seen = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (resultValid) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    bit seen;
    int r0, c0;
    logic [11:0] held;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(convStartN == 1'b1 && sclk == 1'b0, "R1 pins in reset", {convStartN, sclk}, 2'b10);
    check(resultValid == 1'b0 && result == 12'h0 && leadErr == 1'b0, "R1 outputs in reset",
          {resultValid, leadErr, result}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(convStartN == 1'b1 && sclk == 1'b0 && !resultValid, "R1 after release",
          {convStartN, sclk, resultValid}, 3'b100);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      nextWord = VEC[v];
      r0 = riseTotal;
      pulseReq();
      waitValid(seen);
      check(seen, "R5 valid strobe seen", seen, 1);
      check(result == VEC[v][11:0], "R5 result bits", result, VEC[v][11:0]);
      check(leadErr == (VEC[v][15:12] != 4'h0), "R6 leading error flag", leadErr,
            VEC[v][15:12] != 4'h0);
      check(riseTotal - r0 == 16, "R4 pulse count", riseTotal - r0, 16);
      check(lastLowWidth == CONV_LOW, "R2 convert pulse width", lastLowWidth, CONV_LOW);
      check(lastGap >= GUARD, "R7 quiet interval", lastGap, GUARD);
      held = result;
      @(negedge clk);
      check(!resultValid, "R5 strobe is one cycle", resultValid, 0);
      repeat (20) @(negedge clk);
      check(result == held && sclk == 1'b0, "R9 result held, R4 clock parked",
            {sclk, result}, {1'b0, held});
    end
    check(busyViol == 0, "R3 no sclk rise while busy", busyViol, 0);
    check(widthBad == 0, "R4 sclk high/low widths", widthBad, 0);

    // R2 direct launch latency after long idle
    repeat (60) @(negedge clk);
    nextWord = 16'h0123;
    startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    check(convStartN == 1'b0, "R2 launch at sampling edge", convStartN, 0);
    waitValid(seen);
    check(seen && result == 12'h123 && !leadErr, "R5 direct read", result, 12'h123);

    // R8 burst of requests during a conversion, plus hold-off timing
    repeat (60) @(negedge clk);
    c0 = convFalls;
    nextWord = 16'h0456;
    pulseReq();
    repeat (2) @(negedge clk);
    pulseReq();
    pulseReq();
    waitValid(seen);
    check(seen && result == 12'h456, "R8 first read of burst", result, 12'h456);
    nextWord = 16'hF00F;
    waitValid(seen);
    check(seen && result == 12'h00F && leadErr, "R8 held request read, R6 flag",
          {leadErr, result}, {1'b1, 12'h00F});
    check(lastGap == GUARD + 1, "R8 held request launch time", lastGap, GUARD + 1);
    repeat (400) @(negedge clk);
    check(convFalls - c0 == 2, "R8 burst gives one extra conversion", convFalls - c0, 2);
    check(!resultValid && result == 12'h00F && leadErr, "R9 hold after burst",
          {leadErr, result}, {1'b1, 12'h00F});
    check(busyViol == 0 && widthBad == 0, "R3 R4 over full run", busyViol + widthBad, 0);

    finish();
  end

endmodule